// File: doc/BRIEF.md
# Potentiometer command sequencer

This block sits between a two-wire serial slave front end and the wiper counters of a dual digital potentiometer. Once the front end has recognised its slave address, the block reads the instruction byte that follows. It decides whether a third byte follows, answers each byte with an acknowledge decision, and puts read data in front of the serial transmitter. It keeps four W-bit data registers per channel. Their retention cells are modelled as flops, with a cycle-count timer that stands in for the programming time.

Register changes are held as pending until a stop condition closes a complete sequence. At that stop the block issues wiper load requests, or it updates the data registers and starts the busy timer. While the timer runs, new address phases are refused. In step mode the block turns every SCL high pulse into an up or down step request for one wiper, and the SDA level sets the direction. The write-protect pin, when low, stops any change to the data registers.

Top module: `potcmd_seq`

## Requirements
- R1: After reset, busy_o, ack_o, wload_o and step_o are low, and every data register reads as zero.
- R2: A sel_i pulse is acknowledged (ack_o high for one cycle, the cycle after sel_i) when busy_o is low and refused (ack_o low) while busy_o is high. The instruction byte is always acknowledged.
- R3: The instruction byte is {op[3:0], reg[1:0], rsv, ch}, with reg in bits 3:2, the reserved bit in bit 1 and the channel in bit 0. Op 1100 followed by a data byte {2'b00, D} writes D to data register reg of channel ch at the stop. Op 1011 makes rd_data_o equal {2'b00, register} in the cycle after the instruction byte.
- R4: Op 1010 followed by a data byte raises wload_o[ch] for one cycle after the stop, with wload_val_o slice ch (bits W*ch+W-1:W*ch) equal to D. Op 1001 puts {2'b00, wiper_i slice ch} on rd_data_o.
- R5: Op 1101 loads wiper ch from data register reg at the stop. Op 1110 stores wiper ch into data register reg at the stop.
- R6: Op 0001 loads both wipers from their own register reg. Op 1000 stores both wipers into their own register reg. The channel bit is ignored for both.
- R7: Op 0010 enters step mode until the stop. Each scl_hi_i pulse gives a one-cycle step_o[ch] pulse, with step_up_o equal to the sda_i level of that pulse.
- R8: A stop that changes data registers (ops 1100, 1110, 1000) holds busy_o high for exactly BUSY_CYC cycles. Wiper-only commands do not raise busy_o.
- R9: With wp_n_i low at the stop, data-register changes are dropped and busy_o stays low.
- R10: A sequence cut short has no effect. This covers a stop before the data byte, and a start before the stop. A byte beyond a complete sequence is not acknowledged and cancels the pending action.
- R11: An undefined op, or an instruction with bit 1 set, is acknowledged and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| wp_n_i | input | 1 | write protect, low blocks data-register changes |
| start_i | input | 1 | pulse: start condition seen on the bus |
| sel_i | input | 1 | pulse: slave address matched |
| rx_valid_i | input | 1 | pulse: a byte from the master is complete |
| rx_byte_i | input | 8 | received byte |
| stop_i | input | 1 | pulse: stop condition seen |
| scl_hi_i | input | 1 | pulse: SCL rising edge after the instruction byte |
| sda_i | input | 1 | SDA level at that SCL edge |
| wiper_i | input | 2*W | current wiper positions, channel 1 in the upper half |
| ack_o | output | 1 | acknowledge decision for the last address or byte |
| rd_data_o | output | 8 | byte for the transmitter on read commands |
| busy_o | output | 1 | programming timer running |
| wload_o | output | 2 | per-channel wiper load request |
| wload_val_o | output | 2*W | values to load, channel 1 in the upper half |
| step_o | output | 2 | per-channel wiper step request |
| step_up_o | output | 1 | step direction, 1 toward the high end |

## Verification
The bench targets the exact busy window and the refusal of an address while it runs. A timer that is off by one would let a new sequence in one cycle early, or refuse one cycle too long. Truncated and overlong sequences are driven to catch a design that commits on any stop, not only after a complete sequence. Write protect on stores, the reserved bit and undefined ops are also driven: a faulty design would either write anyway or start a busy cycle for nothing. Step mode is driven past the top of the wiper range in both directions, to show that direction follows SDA on each pulse and goes to the right channel.

// File: rtl/potcmd_seq.sv
module potcmd_seq #(
  parameter int W        = 6,
  parameter int BUSY_CYC = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wp_n_i,
  input  logic           start_i,
  input  logic           sel_i,
  input  logic           rx_valid_i,
  input  logic [7:0]     rx_byte_i,
  input  logic           stop_i,
  input  logic           scl_hi_i,
  input  logic           sda_i,
  input  logic [2*W-1:0] wiper_i,
  output logic           ack_o,
  output logic [7:0]     rd_data_o,
  output logic           busy_o,
  output logic [1:0]     wload_o,
  output logic [2*W-1:0] wload_val_o,
  output logic [1:0]     step_o,
  output logic           step_up_o
);
  localparam int CW   = $clog2(BUSY_CYC + 1);
  localparam int NREG = 4;
  localparam int PADW = 8 - W;

  localparam logic [3:0] OP_RDW  = 4'b1001;
  localparam logic [3:0] OP_WRW  = 4'b1010;
  localparam logic [3:0] OP_RDD  = 4'b1011;
  localparam logic [3:0] OP_WRD  = 4'b1100;
  localparam logic [3:0] OP_D2W  = 4'b1101;
  localparam logic [3:0] OP_W2D  = 4'b1110;
  localparam logic [3:0] OP_GD2W = 4'b0001;
  localparam logic [3:0] OP_GW2D = 4'b1000;
  localparam logic [3:0] OP_STEP = 4'b0010;

  typedef enum logic [2:0] {S_IDLE, S_INSTR, S_DATA, S_DONE, S_STEP, S_DEAD} st_t;

  st_t          st;
  logic [3:0]   op;
  logic [1:0]   rsel;
  logic         ch;
  logic         pend;
  logic [W-1:0] wdat;
  logic [W-1:0] dr [2][NREG];
  logic [CW-1:0] bcnt;

  logic [W-1:0] wip [2];
  assign wip[0] = wiper_i[W-1:0];
  assign wip[1] = wiper_i[2*W-1:W];

  wire [3:0] n_op  = rx_byte_i[7:4];
  wire [1:0] n_reg = rx_byte_i[3:2];
  wire       n_ch  = rx_byte_i[0];
  wire       n_bad = rx_byte_i[1];

  wire commit = !start_i && stop_i && st == S_DONE && pend;
  wire is_store = op == OP_WRD || op == OP_W2D || op == OP_GW2D;
  wire store = commit && is_store && wp_n_i;

  assign busy_o = bcnt != '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bcnt <= '0;
    else if (store) bcnt <= CW'(BUSY_CYC);
    else if (busy_o) bcnt <= bcnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      op          <= '0;
      rsel        <= '0;
      ch          <= 1'b0;
      pend        <= 1'b0;
      wdat        <= '0;
      ack_o       <= 1'b0;
      rd_data_o   <= '0;
      wload_o     <= '0;
      wload_val_o <= '0;
      step_o      <= '0;
      step_up_o   <= 1'b0;
      for (int c = 0; c < 2; c++)
        for (int r = 0; r < NREG; r++)
          dr[c][r] <= '0;
    end else begin
      ack_o   <= 1'b0;
      wload_o <= '0;
      step_o  <= '0;
      if (start_i) begin
        st   <= S_IDLE;
        pend <= 1'b0;
      end else if (stop_i) begin
        if (commit) begin
          case (op)
            OP_WRW: begin
              wload_o[ch] <= 1'b1;
              if (ch) wload_val_o[2*W-1:W] <= wdat;
              else    wload_val_o[W-1:0]   <= wdat;
            end
            OP_D2W: begin
              wload_o[ch] <= 1'b1;
              if (ch) wload_val_o[2*W-1:W] <= dr[1][rsel];
              else    wload_val_o[W-1:0]   <= dr[0][rsel];
            end
            OP_GD2W: begin
              wload_o     <= 2'b11;
              wload_val_o <= {dr[1][rsel], dr[0][rsel]};
            end
            OP_WRD: if (wp_n_i) dr[ch][rsel] <= wdat;
            OP_W2D: if (wp_n_i) dr[ch][rsel] <= wip[ch];
            OP_GW2D: if (wp_n_i) begin
              dr[0][rsel] <= wip[0];
              dr[1][rsel] <= wip[1];
            end
            default: ;
          endcase
        end
        st   <= S_IDLE;
        pend <= 1'b0;
      end else if (sel_i) begin
        pend <= 1'b0;
        if (busy_o) st <= S_IDLE;
        else begin
          st    <= S_INSTR;
          ack_o <= 1'b1;
        end
      end else if (rx_valid_i) begin
        case (st)
          S_INSTR: begin
            ack_o <= 1'b1;
            op    <= n_op;
            rsel  <= n_reg;
            ch    <= n_ch;
            st    <= S_DONE;
            pend  <= 1'b0;
            if (!n_bad) begin
              case (n_op)
                OP_RDW: rd_data_o <= {{PADW{1'b0}}, wip[n_ch]};
                OP_RDD: rd_data_o <= {{PADW{1'b0}}, dr[n_ch][n_reg]};
                OP_WRW, OP_WRD: st <= S_DATA;
                OP_D2W, OP_W2D, OP_GD2W, OP_GW2D: pend <= 1'b1;
                OP_STEP: st <= S_STEP;
                default: ;
              endcase
            end
          end
          S_DATA: begin
            ack_o <= 1'b1;
            wdat  <= rx_byte_i[W-1:0];
            pend  <= 1'b1;
            st    <= S_DONE;
          end
          S_DONE: begin
            st   <= S_DEAD;
            pend <= 1'b0;
          end
          default: ;
        endcase
      end else if (scl_hi_i && st == S_STEP) begin
        step_o[ch] <= 1'b1;
        step_up_o  <= sda_i;
      end
    end
  end
endmodule

module potcmd_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       stop_i,
  input logic       sel_i,
  input logic       scl_hi_i,
  input logic       sda_i,
  input logic       wp_n_i,
  input logic       ack_o,
  input logic       busy_o,
  input logic [1:0] wload_o,
  input logic [1:0] step_o,
  input logic       step_up_o
);
  a_r2_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    sel_i && busy_o |=> !ack_o);
  a_r4_load_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    |wload_o |-> $past(stop_i));
  a_r7_step_from_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    |step_o |-> $past(scl_hi_i) && step_up_o == $past(sda_i));
  a_r7_step_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_o));
  a_r8_busy_from_stop: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(stop_i));
  a_r9_busy_needs_wp: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(wp_n_i));
  a_r10_no_load_and_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wload_o && |step_o));
endmodule

bind potcmd_seq potcmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .sel_i(sel_i),
  .scl_hi_i(scl_hi_i), .sda_i(sda_i), .wp_n_i(wp_n_i), .ack_o(ack_o),
  .busy_o(busy_o), .wload_o(wload_o), .step_o(step_o), .step_up_o(step_up_o)
);

// File: tb/tb_potcmd_seq.sv
module tb_potcmd_seq;
  localparam int W = 6;
  localparam int B = 40;
  localparam logic [3:0] RDW = 4'b1001, WRW = 4'b1010, RDD = 4'b1011, WRD = 4'b1100;
  localparam logic [3:0] D2W = 4'b1101, W2D = 4'b1110, GD2W = 4'b0001, GW2D = 4'b1000, STP = 4'b0010;

  logic clk = 0, rst_n = 0, wp_n = 1;
  logic start = 0, sel = 0, rxv = 0, stop = 0, sclh = 0, sda = 0;
  logic [7:0] rxb = 0;
  logic [W-1:0] bw [2];
  logic ack, busy, stup;
  logic [7:0] rdd;
  logic [1:0] wl, st;
  logic [2*W-1:0] wlv;

  int total = 0, bad = 0;
  logic [W-1:0] ew [2];
  logic [W-1:0] edr [2][4];

  always #4 clk = ~clk;

  potcmd_seq #(.W(W), .BUSY_CYC(B)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n_i(wp_n), .start_i(start), .sel_i(sel),
    .rx_valid_i(rxv), .rx_byte_i(rxb), .stop_i(stop), .scl_hi_i(sclh), .sda_i(sda),
    .wiper_i({bw[1], bw[0]}), .ack_o(ack), .rd_data_o(rdd), .busy_o(busy),
    .wload_o(wl), .wload_val_o(wlv), .step_o(st), .step_up_o(stup));

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (wl[c]) bw[c] <= c ? wlv[2*W-1:W] : wlv[W-1:0];
      else if (st[c]) begin
        if (stup && bw[c] != '1) bw[c] <= bw[c] + 1'b1;
        else if (!stup && bw[c] != '0) bw[c] <= bw[c] - 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic ev_start;
    @(negedge clk) start = 1; @(negedge clk) start = 0;
  endtask
  task automatic ev_sel(output bit a);
    @(negedge clk) sel = 1; @(negedge clk) sel = 0; a = ack;
  endtask
  task automatic ev_byte(input logic [7:0] b, output bit a);
    @(negedge clk) begin rxv = 1; rxb = b; end
    @(negedge clk) rxv = 0; a = ack;
  endtask
  task automatic ev_stop;
    @(negedge clk) stop = 1; @(negedge clk) stop = 0;
  endtask
  task automatic ev_scl(input bit s);
    @(negedge clk) begin sclh = 1; sda = s; end
    @(negedge clk) sclh = 0;
  endtask
  task automatic wait_idle;
    while (busy) @(negedge clk);
  endtask

  function automatic logic [7:0] ib(input logic [3:0] op, input int r, input int c);
    return {op, 2'(r), 1'b0, 1'(c)};
  endfunction

  task automatic model(input logic [3:0] op, input int r, input int c, input logic [W-1:0] d, input bit wp);
    case (op)
      WRW: ew[c] = d;
      WRD: if (wp) edr[c][r] = d;
      D2W: ew[c] = edr[c][r];
      W2D: if (wp) edr[c][r] = ew[c];
      GD2W: begin ew[0] = edr[0][r]; ew[1] = edr[1][r]; end
      GW2D: if (wp) begin edr[0][r] = ew[0]; edr[1][r] = ew[1]; end
      default: ;
    endcase
  endtask

  task automatic cmd(input logic [3:0] op, input int r, input int c, input logic [W-1:0] d, input bit wp, input string tag);
    bit a;
    wp_n = wp;
    ev_start; ev_sel(a); chk(a, tag, a, 1);
    ev_byte(ib(op, r, c), a); chk(a, tag, a, 1);
    if (op == WRD || op == WRW) begin ev_byte({2'b00, d}, a); chk(a, tag, a, 1); end
    ev_stop;
    model(op, r, c, d, wp);
    repeat (2) @(negedge clk);
    wait_idle;
    wp_n = 1;
  endtask

  task automatic rd(input logic [3:0] op, input int r, input int c, output logic [7:0] v);
    bit a;
    ev_start; ev_sel(a); ev_byte(ib(op, r, c), a);
    v = rdd;
    ev_stop;
  endtask

  task automatic chk_state(input string tag);
    logic [7:0] v;
    for (int c = 0; c < 2; c++) begin
      chk(bw[c] == ew[c], tag, bw[c], ew[c]);
      for (int r = 0; r < 4; r++) begin
        rd(RDD, r, c, v);
        chk(v == {2'b00, edr[c][r]}, tag, v, edr[c][r]);
      end
      rd(RDW, 0, c, v);
      chk(v == {2'b00, ew[c]}, tag, v, ew[c]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit a;
    logic [7:0] v;
    int seed;
    bw[0] = 0; bw[1] = 0;
    for (int c = 0; c < 2; c++) begin
      ew[c] = 0;
      for (int r = 0; r < 4; r++) edr[c][r] = 0;
    end
    seed = $urandom(32'h5eed1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !ack && wl == 0 && st == 0, "R1", {busy, ack, wl, st}, 0);
    rd(RDD, 3, 1, v); chk(v == 0, "R1", v, 0);

    // R3 / R8 / R2: data write, busy window, refusal
    wp_n = 1;
    ev_start; ev_sel(a); chk(a, "R2", a, 1);
    ev_byte(ib(WRD, 2, 1), a); chk(a, "R2", a, 1);
    ev_byte(8'h2A, a); chk(a, "R3", a, 1);
    ev_stop; edr[1][2] = 6'h2A;
    chk(busy, "R8", busy, 1);
    ev_sel(a); chk(!a, "R2", a, 0);
    ev_start;
    repeat (B - 5) @(negedge clk);
    chk(busy, "R8", busy, 1);
    @(negedge clk); chk(!busy, "R8", busy, 0);
    rd(RDD, 2, 1, v); chk(v == 8'h2A, "R3", v, 8'h2A);

    // R9 write protect on data write
    wp_n = 0;
    ev_start; ev_sel(a); ev_byte(ib(WRD, 1, 0), a); ev_byte(8'h15, a); ev_stop;
    chk(!busy, "R9", busy, 0);
    wp_n = 1;
    rd(RDD, 1, 0, v); chk(v == 0, "R9", v, 0);

    // R4 wiper write, no busy
    ev_start; ev_sel(a); ev_byte(ib(WRW, 0, 0), a); ev_byte(8'h30, a); ev_stop;
    chk(!busy, "R8", busy, 0);
    chk(wl == 2'b01 && wlv[W-1:0] == 6'h30, "R4", wlv[W-1:0], 6'h30);
    ew[0] = 6'h30;
    @(negedge clk);
    rd(RDW, 0, 0, v); chk(v == 8'h30, "R4", v, 8'h30);

    // R5 transfers
    cmd(D2W, 2, 1, 0, 1, "R5");
    chk(bw[1] == 6'h2A, "R5", bw[1], 6'h2A);
    cmd(W2D, 3, 0, 0, 1, "R5");
    rd(RDD, 3, 0, v); chk(v == 8'h30, "R5", v, 8'h30);

    // R6 global transfers
    cmd(WRD, 1, 0, 6'd5, 1, "R6");
    cmd(WRD, 1, 1, 6'd9, 1, "R6");
    cmd(GD2W, 1, 1, 0, 1, "R6");
    chk(bw[0] == 5 && bw[1] == 9, "R6", {bw[1], bw[0]}, {6'd9, 6'd5});
    cmd(GW2D, 0, 0, 0, 1, "R6");
    chk_state("R6");

    // R7 step mode, saturation at top
    cmd(WRW, 0, 1, 6'd62, 1, "R7");
    ev_start; ev_sel(a); ev_byte(ib(STP, 0, 1), a); chk(a, "R7", a, 1);
    for (int i = 0; i < 3; i++) begin
      ev_scl(1); chk(st == 2'b10 && stup, "R7", {st, stup}, 3'b101);
    end
    for (int i = 0; i < 2; i++) begin
      ev_scl(0); chk(st == 2'b10 && !stup, "R7", {st, stup}, 3'b100);
    end
    ev_stop; @(negedge clk);
    ew[1] = 6'd61;
    chk(bw[1] == 6'd61, "R7", bw[1], 61);
    ev_scl(1); chk(st == 0, "R7", st, 0);

    // R10 truncated / overlong sequences
    ev_start; ev_sel(a); ev_byte(ib(WRD, 0, 0), a); ev_stop;
    chk(!busy, "R10", busy, 0);
    ev_start; ev_sel(a); ev_byte(ib(WRW, 0, 0), a); ev_byte(8'h01, a);
    ev_start; ev_stop; @(negedge clk);
    chk(bw[0] == ew[0], "R10", bw[0], ew[0]);
    ev_start; ev_sel(a); ev_byte(ib(WRD, 2, 0), a); ev_byte(8'h11, a);
    ev_byte(8'h22, a); chk(!a, "R10", a, 0);
    ev_stop; chk(!busy, "R10", busy, 0);

    // R11 undefined op and reserved bit
    ev_start; ev_sel(a); ev_byte(8'h70, a); chk(a, "R11", a, 1); ev_stop;
    ev_start; ev_sel(a); ev_byte(8'hC2, a); chk(a, "R11", a, 1);
    ev_byte(8'h3F, a); ev_stop;
    chk(!busy, "R11", busy, 0);
    ev_start; ev_sel(a); ev_byte(8'hE2, a); ev_stop;
    chk(!busy && wl == 0, "R11", busy, 0);
    chk_state("R11");

    // random mix
    for (int i = 0; i < 40; i++) begin
      logic [3:0] op;
      int k;
      k = $urandom_range(0, 5);
      op = (k == 0) ? WRD : (k == 1) ? WRW : (k == 2) ? D2W : (k == 3) ? W2D : (k == 4) ? GD2W : GW2D;
      cmd(op, $urandom_range(0, 3), $urandom_range(0, 1), 6'($urandom), ($urandom_range(0, 3) != 0), "R3");
      @(negedge clk);
      chk(bw[0] == ew[0] && bw[1] == ew[1], "R5", {bw[1], bw[0]}, {ew[1], ew[0]});
    end
    chk_state("R6");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule